// File: doc/BRIEF.md
# PTP Event Frame Timestamp Unit

This block sits beside a byte-wide Ethernet MAC datapath and stamps precision-time event frames in hardware. It runs an 80-bit time counter of its own, 48 bits of seconds and 32 bits of nanoseconds, and samples it on the first byte of every frame. The first byte is the destination address byte that follows the start-of-frame delimiter.

As the frame goes by, the parser looks for time-sync messages carried straight over Ethernet, with EtherType 0x88F7 and no IP layer. It takes the message type and the sequence number from the sync header. The frame counts as an event frame when the message type is Sync, Delay_Req, Pdelay_Req or Pdelay_Resp. For each event frame, a record is queued that holds the sampled time, the message type, the sequence number and the direction. A level interrupt tells the host that records are waiting, and the host pops them one at a time. This suits two-step operation, where software reads back the transmit time and sends it in a later follow-up message.

For received frames there is an in-band option. In that mode the nanoseconds of the arrival time are written into the four reserved bytes of the sync header, and the frame leaves no record in the queue.

Top module: `ptp_evt_stamp`

## Requirements
- R1: The time counter adds NS_STEP nanoseconds each cycle. When the nanoseconds would reach 1,000,000,000 they wrap to the remainder and the seconds go up by one. A load pulse sets both fields, and the loaded value appears on the time outputs in the next cycle.
- R2: A frame is an event frame when frame bytes 12 and 13 hold 0x88F7 (high byte first) and the low nibble of byte 14 is 0, 1, 2 or 3. The high nibble of byte 14 is ignored. Any other EtherType or message type leaves no record.
- R3: The time stored in a record is the counter value in the cycle in which the frame's first byte (din_sof high) is accepted.
- R4: The record holds the message type, the sequence number and the direction bit (1 = transmit). The sequence number is frame bytes 44 and 45, high byte first. The record is at the head of the queue in the cycle after byte 45 is accepted.
- R5: irq is high exactly while the queue holds at least one record. A cycle with rd_en high removes the head record. Records leave in arrival order, and rd_en on an empty queue has no effect.
- R6: A record that arrives while the queue holds DEPTH records is dropped, and the records already held are kept. The drop sets ovf, which stays high until an ovf_clr pulse.
- R7: While inband_en is high, an event frame received with din_dir = 0 has bytes 30 to 33 replaced on dout_data by its sampled nanoseconds, most significant byte first, and queues no record. A transmitted frame under inband_en is queued and passes unchanged.
- R8: Every byte that is not replaced appears on dout_data unchanged in the same cycle.
- R9: A frame that ends (din_eof) before byte 45 queues no record.
- R10: After reset the queue is empty, irq and ovf are low, and the seconds are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tm_load | input | 1 | Load pulse for the time counter |
| tm_load_sec | input | 48 | Seconds to load |
| tm_load_ns | input | 32 | Nanoseconds to load, below 10^9 |
| cur_sec | output | 48 | Current seconds |
| cur_ns | output | 32 | Current nanoseconds |
| din_valid | input | 1 | Byte strobe |
| din_sof | input | 1 | Marks the first byte of a frame |
| din_eof | input | 1 | Marks the last byte of a frame |
| din_dir | input | 1 | Frame direction, 1 = transmit, sampled on the first byte |
| din_data | input | 8 | Frame byte |
| inband_en | input | 1 | Selects in-band stamping for received frames |
| dout_data | output | 8 | Frame byte out, possibly with the time written in |
| rd_en | input | 1 | Pops the head record |
| rec_dir | output | 1 | Head record direction |
| rec_mtype | output | 4 | Head record message type |
| rec_seq | output | 16 | Head record sequence number |
| rec_sec | output | 48 | Head record seconds |
| rec_ns | output | 32 | Head record nanoseconds |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Queue not empty |

## Verification
The in-band byte change is combinational, so dout_data is checked in the same cycle as the byte that drives it, just after the inputs change at the falling edge. The time sample is taken from cur_sec and cur_ns in the first-byte cycle, because that value is the one registered at the next rising edge. A record is due one edge after byte 45, and a loaded or wrapped counter value is due one edge after the load or carry. The bench therefore reads records and the counter one falling edge after the edge that must have produced them. Pops and flag clears are checked one cycle later in the same way.

// File: rtl/ptp_stamp_pkg.sv
`timescale 1ns/1ps
package ptp_stamp_pkg;
    localparam logic [15:0] SYNC_ETYPE = 16'h88F7;
    localparam int          SEC_W      = 48;
    localparam int          NS_W       = 32;
    localparam int          TS_W       = SEC_W + NS_W;
    localparam int          POS_W      = 6;
    localparam logic [POS_W-1:0] POS_MAX    = '1;
    localparam logic [POS_W-1:0] POS_ET_HI  = 6'd12;
    localparam logic [POS_W-1:0] POS_ET_LO  = 6'd13;
    localparam logic [POS_W-1:0] POS_MTYPE  = 6'd14;
    localparam logic [POS_W-1:0] POS_RSV0   = 6'd30;
    localparam logic [POS_W-1:0] POS_RSV1   = 6'd31;
    localparam logic [POS_W-1:0] POS_RSV2   = 6'd32;
    localparam logic [POS_W-1:0] POS_RSV3   = 6'd33;
    localparam logic [POS_W-1:0] POS_SEQ_HI = 6'd44;
    localparam logic [POS_W-1:0] POS_SEQ_LO = 6'd45;

    typedef struct packed {
        logic            dir;
        logic [3:0]      mtype;
        logic [15:0]     seq;
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } stamp_rec_t;

    localparam int REC_W = $bits(stamp_rec_t);
endpackage

// File: rtl/ptp_time_ctr.sv
`timescale 1ns/1ps
module ptp_time_ctr
    import ptp_stamp_pkg::*;
#(
    parameter int NS_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_sec,
    input  logic [NS_W-1:0]  load_ns,
    output logic [SEC_W-1:0] sec,
    output logic [NS_W-1:0]  ns
);
    localparam logic [NS_W:0] NS_WRAP = 33'd1_000_000_000;
    localparam logic [NS_W:0] STEP    = (NS_W+1)'(NS_STEP);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ctr_t;

    ctr_t c_d, c_q;
    logic [NS_W:0] sum;

    always_comb begin
        c_d = c_q;
        sum = {1'b0, c_q.ns} + STEP;
        if (load) begin
            c_d.sec = load_sec;
            c_d.ns  = load_ns;
        end else if (sum >= NS_WRAP) begin
            c_d.ns  = NS_W'(sum - NS_WRAP);
            c_d.sec = c_q.sec + 1'b1;
        end else begin
            c_d.ns  = sum[NS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign sec = c_q.sec;
    assign ns  = c_q.ns;

    // R1
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> c_q.ns < NS_WRAP[NS_W-1:0]);

    // R1
    ns_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ({1'b0, c_q.ns} + STEP >= NS_WRAP)) |=> c_q.sec == $past(c_q.sec) + 1'b1);
endmodule

// File: rtl/ptp_frame_parse.sv
`timescale 1ns/1ps
module ptp_frame_parse
    import ptp_stamp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_W-1:0] now_sec,
    input  logic [NS_W-1:0]  now_ns,
    input  logic             din_valid,
    input  logic             din_sof,
    input  logic             din_eof,
    input  logic             din_dir,
    input  logic [7:0]       din_data,
    input  logic             inband_en,
    output logic [7:0]       dout_data,
    output logic             push,
    output stamp_rec_t       rec
);
    typedef struct packed {
        logic             active;
        logic [POS_W-1:0] pos;
        logic             dir;
        logic [7:0]       et_hi;
        logic             eth_ok;
        logic             evt;
        logic [3:0]       mtype;
        logic [7:0]       seq_hi;
        logic [TS_W-1:0]  ts;
    } prs_t;

    prs_t s_d, s_q;
    logic take;
    logic [POS_W-1:0] pos;
    logic dir_now;
    logic rx_inband;

    always_comb begin
        s_d       = s_q;
        push      = 1'b0;
        dout_data = din_data;
        take      = din_valid && (din_sof || s_q.active);
        pos       = din_sof ? '0 : s_q.pos;
        dir_now   = din_sof ? din_dir : s_q.dir;
        rx_inband = inband_en && !dir_now;
        rec       = '{dir: dir_now, mtype: s_q.mtype, seq: {s_q.seq_hi, din_data},
                      sec: s_q.ts[TS_W-1:NS_W], ns: s_q.ts[NS_W-1:0]};
        if (take) begin
            if (din_sof) begin
                s_d.ts     = {now_sec, now_ns};
                s_d.dir    = din_dir;
                s_d.eth_ok = 1'b0;
                s_d.evt    = 1'b0;
            end
            s_d.active = !din_eof;
            s_d.pos    = (pos == POS_MAX) ? pos : pos + 1'b1;
            case (pos)
                POS_ET_HI:  s_d.et_hi  = din_data;
                POS_ET_LO:  s_d.eth_ok = ({s_q.et_hi, din_data} == SYNC_ETYPE);
                POS_MTYPE: begin
                    s_d.mtype = din_data[3:0];
                    s_d.evt   = s_q.eth_ok && (din_data[3:0] <= 4'd3);
                end
                POS_SEQ_HI: s_d.seq_hi = din_data;
                POS_SEQ_LO: push = s_q.evt && !rx_inband;
                default: ;
            endcase
            if (s_q.evt && rx_inband) begin
                case (pos)
                    POS_RSV0: dout_data = s_q.ts[31:24];
                    POS_RSV1: dout_data = s_q.ts[23:16];
                    POS_RSV2: dout_data = s_q.ts[15:8];
                    POS_RSV3: dout_data = s_q.ts[7:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(din_valid && din_sof) |=> $stable(s_q.ts));

    // R8
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_data != din_data) |-> (take && inband_en && s_q.evt));
endmodule

// File: rtl/ptp_rec_fifo.sv
`timescale 1ns/1ps
module ptp_rec_fifo
    import ptp_stamp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  stamp_rec_t wdata,
    input  logic       pop,
    input  logic       ovf_clr,
    output stamp_rec_t rdata,
    output logic       nonempty,
    output logic       ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
        logic          ovf;
    } fq_t;

    fq_t f_d, f_q;
    stamp_rec_t mem_d [DEPTH];
    stamp_rec_t mem_q [DEPTH];
    logic do_pop, do_push;

    always_comb begin
        f_d     = f_q;
        mem_d   = mem_q;
        do_pop  = pop && (f_q.cnt != '0);
        do_push = push && ((f_q.cnt != FULL) || do_pop);
        if (ovf_clr) f_d.ovf = 1'b0;
        if (push && !do_push) f_d.ovf = 1'b1;
        if (do_push) begin
            mem_d[f_q.wp] = wdata;
            f_d.wp = (f_q.wp == AW'(DEPTH-1)) ? '0 : f_q.wp + 1'b1;
        end
        if (do_pop) f_d.rp = (f_q.rp == AW'(DEPTH-1)) ? '0 : f_q.rp + 1'b1;
        f_d.cnt = f_q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata    = mem_q[f_q.rp];
    assign nonempty = (f_q.cnt != '0);
    assign ovf      = f_q.ovf;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= FULL);

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && f_q.cnt == FULL && !pop) |=> (f_q.ovf && $stable(f_q.cnt)));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.ovf && !ovf_clr) |=> f_q.ovf);

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && f_q.cnt == '0) |=> f_q.cnt == '0);
endmodule

// File: rtl/ptp_evt_stamp.sv
`timescale 1ns/1ps
module ptp_evt_stamp
    import ptp_stamp_pkg::*;
#(
    parameter int NS_STEP = 4,
    parameter int DEPTH   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tm_load,
    input  logic [47:0] tm_load_sec,
    input  logic [31:0] tm_load_ns,
    output logic [47:0] cur_sec,
    output logic [31:0] cur_ns,
    input  logic        din_valid,
    input  logic        din_sof,
    input  logic        din_eof,
    input  logic        din_dir,
    input  logic [7:0]  din_data,
    input  logic        inband_en,
    output logic [7:0]  dout_data,
    input  logic        rd_en,
    output logic        rec_dir,
    output logic [3:0]  rec_mtype,
    output logic [15:0] rec_seq,
    output logic [47:0] rec_sec,
    output logic [31:0] rec_ns,
    input  logic        ovf_clr,
    output logic        ovf,
    output logic        irq
);
    stamp_rec_t wr_rec, rd_rec;
    logic       wr_push;

    ptp_time_ctr #(.NS_STEP(NS_STEP)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .load_sec(tm_load_sec),
        .load_ns(tm_load_ns), .sec(cur_sec), .ns(cur_ns)
    );

    ptp_frame_parse i_parse (
        .clk(clk), .rst_n(rst_n), .now_sec(cur_sec), .now_ns(cur_ns),
        .din_valid(din_valid), .din_sof(din_sof), .din_eof(din_eof),
        .din_dir(din_dir), .din_data(din_data), .inband_en(inband_en),
        .dout_data(dout_data), .push(wr_push), .rec(wr_rec)
    );

    ptp_rec_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .wdata(wr_rec),
        .pop(rd_en), .ovf_clr(ovf_clr), .rdata(rd_rec),
        .nonempty(irq), .ovf(ovf)
    );

    assign rec_dir   = rd_rec.dir;
    assign rec_mtype = rd_rec.mtype;
    assign rec_seq   = rd_rec.seq;
    assign rec_sec   = rd_rec.sec;
    assign rec_ns    = rd_rec.ns;

    // R4
    seq_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_push |=> irq);
endmodule

// File: tb/test_ptp_evt_stamp.sv
`timescale 1ns/1ps
module test_ptp_evt_stamp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tm_load = 1'b0;
    logic [47:0] tm_load_sec = '0;
    logic [31:0] tm_load_ns = '0;
    logic [47:0] cur_sec;
    logic [31:0] cur_ns;
    logic        din_valid = 1'b0, din_sof = 1'b0, din_eof = 1'b0, din_dir = 1'b0;
    logic [7:0]  din_data = '0;
    logic        inband_en = 1'b0;
    logic [7:0]  dout_data;
    logic        rd_en = 1'b0;
    logic        rec_dir;
    logic [3:0]  rec_mtype;
    logic [15:0] rec_seq;
    logic [47:0] rec_sec;
    logic [31:0] rec_ns;
    logic        ovf_clr = 1'b0;
    logic        ovf, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ptp_evt_stamp i_ptp_evt_stamp (.*);

    typedef struct packed {
        logic        dir;
        logic [15:0] et;
        logic [3:0]  mt;
        logic [15:0] seq;
        logic        inb;
        logic        exp_rec;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 16'h88F7, 4'd0, 16'h1234, 1'b0, 1'b1},
        '{1'b1, 16'h88F7, 4'd1, 16'h0001, 1'b0, 1'b1},
        '{1'b0, 16'h88F7, 4'd3, 16'hBEEF, 1'b0, 1'b1},
        '{1'b0, 16'h88F7, 4'd8, 16'h0005, 1'b0, 1'b0},
        '{1'b0, 16'h0800, 4'd0, 16'h0006, 1'b0, 1'b0},
        '{1'b0, 16'h88F7, 4'd4, 16'h0007, 1'b0, 1'b0},
        '{1'b0, 16'h88F7, 4'd2, 16'h7777, 1'b1, 1'b0},
        '{1'b1, 16'h88F7, 4'd0, 16'hCAFE, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int k, input logic [15:0] et,
                                           input logic [3:0] mt, input logic [15:0] seq);
        case (k)
            12: return et[15:8];
            13: return et[7:0];
            14: return {4'hB, mt};
            44: return seq[15:8];
            45: return seq[7:0];
            default: return 8'(k * 7 + 1);
        endcase
    endfunction

    task automatic send_frame(input logic dir, input logic [15:0] et, input logic [3:0] mt,
                              input logic [15:0] seq, input int len, input logic inb,
                              output logic [79:0] ts, output bit data_ok);
        logic [79:0] t = '0;
        logic [7:0]  e;
        bit edit = inb && !dir && (et == 16'h88F7) && (mt <= 4'd3);
        data_ok = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            din_valid = 1'b1; din_sof = (k == 0); din_eof = (k == len - 1);
            din_dir = dir; inband_en = inb; din_data = byte_of(k, et, mt, seq);
            #1;
            if (k == 0) t = {cur_sec, cur_ns};
            e = din_data;
            if (edit && k >= 30 && k <= 33) e = t[(31 - 8 * (k - 30)) -: 8];
            if (dout_data != e) data_ok = 1'b0;
        end
        @(negedge clk);
        din_valid = 1'b0; din_sof = 1'b0; din_eof = 1'b0;
        #1;
        ts = t;
    endtask

    task automatic pop_one();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        #1;
    endtask

    initial begin
        logic [79:0] ts;
        logic [79:0] tsa [5];
        bit dok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk(irq == 1'b0, "R10 irq", irq, 0);
        chk(ovf == 1'b0, "R10 ovf", ovf, 0);
        chk(cur_sec == '0, "R10 seconds", cur_sec, 0);

        // table walk: R2 R3 R4 R5 R7 R8
        for (int i = 0; i < NV; i++) begin
            send_frame(VEC[i].dir, VEC[i].et, VEC[i].mt, VEC[i].seq, 60, VEC[i].inb, ts, dok);
            chk(dok, "R7/R8 output bytes", 0, 0);
            chk(irq == VEC[i].exp_rec, "R2 record presence", irq, VEC[i].exp_rec);
            if (VEC[i].exp_rec) begin
                chk(rec_seq == VEC[i].seq, "R4 seq", rec_seq, VEC[i].seq);
                chk(rec_mtype == VEC[i].mt, "R4 mtype", rec_mtype, VEC[i].mt);
                chk(rec_dir == VEC[i].dir, "R4 dir", rec_dir, VEC[i].dir);
                chk({rec_sec, rec_ns} == ts, "R3 timestamp", {rec_sec, rec_ns}, ts);
                pop_one();
                chk(irq == 1'b0, "R5 empty after pop", irq, 0);
            end
        end

        // R5 pop on empty has no effect
        pop_one();
        chk(irq == 1'b0, "R5 empty pop", irq, 0);

        // R1 load and nanosecond wrap
        @(negedge clk);
        tm_load = 1'b1; tm_load_sec = 48'd5; tm_load_ns = 32'd999_999_992;
        @(negedge clk);
        tm_load = 1'b0;
        #1;
        chk(cur_ns == 32'd999_999_992 && cur_sec == 48'd5, "R1 load", {cur_sec, cur_ns}, {48'd5, 32'd999_999_992});
        @(negedge clk); #1;
        chk(cur_ns == 32'd999_999_996, "R1 step", cur_ns, 32'd999_999_996);
        @(negedge clk); #1;
        chk(cur_ns == 32'd0 && cur_sec == 48'd6, "R1 wrap", {cur_sec, cur_ns}, {48'd6, 32'd0});

        // R9 truncated frame
        send_frame(1'b0, 16'h88F7, 4'd0, 16'h4444, 40, 1'b0, ts, dok);
        chk(irq == 1'b0, "R9 short frame", irq, 0);

        // R6 overflow: five records into a queue of four
        for (int i = 0; i < 5; i++) begin
            send_frame(1'b1, 16'h88F7, 4'd0, 16'(100 + i), 50, 1'b0, tsa[i], dok);
        end
        chk(ovf == 1'b1, "R6 ovf set", ovf, 1);
        for (int i = 0; i < 4; i++) begin
            chk(irq == 1'b1, "R5 irq while holding", irq, 1);
            chk(rec_seq == 16'(100 + i), "R6 order and drop", rec_seq, 100 + i);
            chk({rec_sec, rec_ns} == tsa[i], "R3 queued time", {rec_sec, rec_ns}, tsa[i]);
            pop_one();
        end
        chk(irq == 1'b0, "R6 newest dropped", irq, 0);
        chk(ovf == 1'b1, "R6 ovf sticky", ovf, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        #1;
        chk(ovf == 1'b0, "R6 ovf clear", ovf, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule